// File: doc/BRIEF.md
# Timer-Counter PWM Channel Array

A bank of independent 16-bit timer channels, each producing one pulse-width-modulated output pin. Every channel has an up-counter that advances on a per-channel tick strobe, a duty compare value, a period compare value and a small control register. The output sits at a programmable starting level while the counter is below the duty value. It takes the opposite level from the duty match up to the period match. The counter then wraps to zero. Counters are started and stopped through two shared strobe registers: one sets running bits, the other clears them.

Software reaches every register through a synchronous write port and a combinational read port. A channel is parked at a known level by writing a duty value above its period value. Turning the output off can be abrupt, or it can wait for the running period to end. The number of channels is a parameter; 8, 6 and 5 are the intended configurations.

Top module: `tcpwm_array`

## Requirements
- R1: After reset every counter reads 0, every duty and period register reads 0xFFFF, every control register reads 0, the running-status register reads 0 and every pwm_o bit is 0.
- R2: A write to address 0x20 sets the running bit of each channel whose data bit is 1. Data bits that are 0 leave their channel unchanged. The running bits read back at address 0x22, bit n for channel n.
- R3: A write to address 0x21 clears the running bit of each channel whose data bit is 1. A stopped counter holds its value whatever tick_i does.
- R4: A running counter advances by exactly one on each clock where its tick_i bit is 1, and holds when that bit is 0.
- R5: On a tick while the counter equals the period value, the counter goes to 0. A full cycle therefore lasts period+1 ticks.
- R6: With output enabled and duty <= period, pwm_o[n] equals the starting level while counter < duty. It equals the inverted starting level while counter >= duty.
- R7: When duty > period, pwm_o[n] stays at the starting level for the whole cycle.
- R8: Control register bit 0 is output enable and bit 2 is abrupt shutdown. With enable clear and abrupt set, pwm_o[n] shows the starting level from the clock after the write.
- R9: With abrupt clear, clearing enable leaves the output following the compare logic until the next counter wrap. After that wrap it holds the starting level.
- R10: Channel registers sit at address {1'b0, channel[2:0], sel[1:0]}, where sel 0 is control, 1 is duty, 2 is period and 3 is counter. Each of them reads back what was last written to it, and a write to the counter loads it directly.
- R11: Control register bit 1 selects the starting level: 0 is low, 1 is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| tick_i | input | NUM_CH | Per-channel count strobe |
| pwm_o | output | NUM_CH | Per-channel PWM output |

## Verification
A table of duty, period, starting-level and tick-count combinations is run on one channel. The cases sit just below the duty match, just past it, exactly at the period value and one tick past it. Between them they separate a wrong compare sense, an off-by-one wrap and an inverted starting level. One case has duty above period, which shows whether the parking trick holds the pin. Directed cases use mixed set and clear masks with zero bits, which catch cross-channel disturbance. An enabled output is then turned off both abruptly and gracefully, which shows whether the output waits for the wrap.

// File: rtl/tcpwm_pkg.sv
package tcpwm_pkg;
  localparam int MAX_CH = 8;
  localparam int CH_AW  = 3;
  localparam int SEL_AW = 2;
  localparam int ADDR_W = 1 + CH_AW + SEL_AW;

  localparam logic [SEL_AW-1:0] SEL_CTRL   = 2'd0;
  localparam logic [SEL_AW-1:0] SEL_DUTY   = 2'd1;
  localparam logic [SEL_AW-1:0] SEL_PERIOD = 2'd2;
  localparam logic [SEL_AW-1:0] SEL_COUNT  = 2'd3;

  localparam logic [SEL_AW-1:0] G_RUN_SET = 2'd0;
  localparam logic [SEL_AW-1:0] G_RUN_CLR = 2'd1;
  localparam logic [SEL_AW-1:0] G_RUN_STS = 2'd2;

  typedef struct packed {
    logic abrupt;
    logic init_hi;
    logic out_en;
  } ctrl_t;
endpackage

// File: rtl/tcpwm_run_ctrl.sv
module tcpwm_run_ctrl #(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_we_i,
  input  logic              clr_we_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic [NUM_CH-1:0] run_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_o <= '0;
    else if (set_we_i) run_o <= run_o | mask_i;
    else if (clr_we_i) run_o <= run_o & ~mask_i;
  end
endmodule

// File: rtl/tcpwm_channel.sv
module tcpwm_channel
  import tcpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             wr_ctrl_i,
  input  logic             wr_duty_i,
  input  logic             wr_period_i,
  input  logic             wr_cnt_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] duty_o,
  output logic [CNT_W-1:0] period_o,
  output ctrl_t            ctrl_o,
  output logic             pwm_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic  drain_q;
  logic  step;
  logic  wrap;
  logic  active;
  ctrl_t ctrl_d;
  logic  unused_wdata;

  assign ctrl_d       = ctrl_t'(wdata_i[CTRL_W-1:0]);
  assign unused_wdata = ^wdata_i[CNT_W-1:CTRL_W];
  assign step         = run_i & tick_i;
  assign wrap         = step & (cnt_o == period_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      duty_o   <= '1;
      period_o <= '1;
      ctrl_o   <= '0;
      drain_q  <= 1'b0;
    end else begin
      if (wr_cnt_i)  cnt_o <= wdata_i;
      else if (step) cnt_o <= wrap ? '0 : cnt_o + 1'b1;
      if (wr_duty_i)   duty_o   <= wdata_i;
      if (wr_period_i) period_o <= wdata_i;
      if (wr_ctrl_i) begin
        ctrl_o  <= ctrl_d;
        // graceful off: keep output live until the period ends
        drain_q <= (ctrl_o.out_en | drain_q) & ~ctrl_d.out_en & ~ctrl_d.abrupt;
      end else if (wrap) begin
        drain_q <= 1'b0;
      end
    end
  end

  assign active = (cnt_o >= duty_o) && (duty_o <= period_o);
  assign pwm_o  = ctrl_o.init_hi ^ ((ctrl_o.out_en | drain_q) & active);
endmodule

// File: rtl/tcpwm_array.sv
module tcpwm_array
  import tcpwm_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [NUM_CH-1:0] tick_i,
  output logic [NUM_CH-1:0] pwm_o
);
  localparam int CH_LSB = SEL_AW;
  localparam int CH_MSB = SEL_AW + CH_AW - 1;

  logic                          glb_sel;
  logic [CH_AW-1:0]              ch_sel;
  logic [SEL_AW-1:0]             reg_sel;
  logic [NUM_CH-1:0]             run_q;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all;
  logic [NUM_CH-1:0][CNT_W-1:0]  duty_all;
  logic [NUM_CH-1:0][CNT_W-1:0]  period_all;
  ctrl_t [NUM_CH-1:0]            ctrl_all;
  logic [NUM_CH-1:0]             en_all;
  logic [NUM_CH-1:0]             init_all;
  logic [NUM_CH-1:0]             abrupt_all;

  assign glb_sel = addr_i[ADDR_W-1];
  assign ch_sel  = addr_i[CH_MSB:CH_LSB];
  assign reg_sel = addr_i[SEL_AW-1:0];

  tcpwm_run_ctrl #(.NUM_CH(NUM_CH)) u_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (we_i & glb_sel & (reg_sel == G_RUN_SET)),
    .clr_we_i (we_i & glb_sel & (reg_sel == G_RUN_CLR)),
    .mask_i   (wdata_i[NUM_CH-1:0]),
    .run_o    (run_q)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = we_i & ~glb_sel & (ch_sel == CH_AW'(i));

    tcpwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick_i[i]),
      .run_i       (run_q[i]),
      .wr_ctrl_i   (hit & (reg_sel == SEL_CTRL)),
      .wr_duty_i   (hit & (reg_sel == SEL_DUTY)),
      .wr_period_i (hit & (reg_sel == SEL_PERIOD)),
      .wr_cnt_i    (hit & (reg_sel == SEL_COUNT)),
      .wdata_i     (wdata_i),
      .cnt_o       (cnt_all[i]),
      .duty_o      (duty_all[i]),
      .period_o    (period_all[i]),
      .ctrl_o      (ctrl_all[i]),
      .pwm_o       (pwm_o[i])
    );

    assign en_all[i]     = ctrl_all[i].out_en;
    assign init_all[i]   = ctrl_all[i].init_hi;
    assign abrupt_all[i] = ctrl_all[i].abrupt;
  end

  always_comb begin
    rdata_o = '0;
    if (!glb_sel) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_sel == CH_AW'(i)) begin
          case (reg_sel)
            SEL_CTRL:   rdata_o[$bits(ctrl_t)-1:0] = ctrl_all[i];
            SEL_DUTY:   rdata_o = duty_all[i];
            SEL_PERIOD: rdata_o = period_all[i];
            default:    rdata_o = cnt_all[i];
          endcase
        end
      end
    end else if (reg_sel == G_RUN_STS) begin
      rdata_o[NUM_CH-1:0] = run_q;
    end
  end
endmodule

// File: rtl/tcpwm_array_chk.sv
module tcpwm_array_chk
  import tcpwm_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         we_i,
  input logic [ADDR_W-1:0]            addr_i,
  input logic [CNT_W-1:0]             wdata_i,
  input logic [NUM_CH-1:0]            tick_i,
  input logic [NUM_CH-1:0]            pwm_o,
  input logic [NUM_CH-1:0]            run_q,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
  input logic [NUM_CH-1:0][CNT_W-1:0] duty_all,
  input logic [NUM_CH-1:0][CNT_W-1:0] period_all,
  input logic [NUM_CH-1:0]            en_all,
  input logic [NUM_CH-1:0]            init_all,
  input logic [NUM_CH-1:0]            abrupt_all
);
  localparam logic [ADDR_W-1:0] A_SET = {1'b1, {CH_AW{1'b0}}, G_RUN_SET};
  localparam logic [ADDR_W-1:0] A_CLR = {1'b1, {CH_AW{1'b0}}, G_RUN_CLR};

  assert_set_starts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SET) |=>
      ((run_q & $past(wdata_i[NUM_CH-1:0])) == $past(wdata_i[NUM_CH-1:0])));

  assert_clr_stops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CLR) |=> ((run_q & $past(wdata_i[NUM_CH-1:0])) == '0));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    logic cnt_wr;
    assign cnt_wr = we_i && addr_i == {1'b0, CH_AW'(n), SEL_COUNT};

    assert_stopped_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q[n] && !cnt_wr) |=> $stable(cnt_all[n]));

    assert_idle_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i[n] && !cnt_wr) |=> $stable(cnt_all[n]));

    assert_wrap_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q[n] && tick_i[n] && cnt_all[n] == period_all[n] && !cnt_wr) |=>
        (cnt_all[n] == '0));

    assert_duty_park_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (duty_all[n] > period_all[n] && cnt_all[n] <= period_all[n]) |->
        (pwm_o[n] == init_all[n]));

    assert_abrupt_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (abrupt_all[n] && !en_all[n]) |-> (pwm_o[n] == init_all[n]));
  end
endmodule

bind tcpwm_array tcpwm_array_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tcpwm_array_test.sv
module tcpwm_array_test;
  localparam int NUM_CH = 8;
  localparam int CNT_W  = 16;
  localparam int AW     = 6;

  typedef struct packed {
    logic [15:0] duty;
    logic [15:0] period;
    logic [15:0] ticks;
    logic [15:0] exp_cnt;
    logic        init_hi;
    logic        exp_pwm;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'd3,  16'd9, 16'd2,  16'd2, 1'b0, 1'b0},
    '{16'd3,  16'd9, 16'd5,  16'd5, 1'b0, 1'b1},
    '{16'd3,  16'd9, 16'd5,  16'd5, 1'b1, 1'b0},
    '{16'd3,  16'd9, 16'd10, 16'd0, 1'b0, 1'b0},
    '{16'd3,  16'd9, 16'd9,  16'd9, 1'b0, 1'b1},
    '{16'd12, 16'd9, 16'd9,  16'd9, 1'b0, 1'b0},
    '{16'd0,  16'd4, 16'd0,  16'd0, 1'b0, 1'b1},
    '{16'd4,  16'd4, 16'd4,  16'd4, 1'b0, 1'b1},
    '{16'd4,  16'd4, 16'd7,  16'd2, 1'b0, 1'b0}
  };

  localparam logic [AW-1:0] A_SET = 6'h20;
  localparam logic [AW-1:0] A_CLR = 6'h21;
  localparam logic [AW-1:0] A_STS = 6'h22;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we_i = 1'b0;
  logic [AW-1:0]     addr_i = '0;
  logic [CNT_W-1:0]  wdata_i = '0;
  logic [CNT_W-1:0]  rdata_o;
  logic [NUM_CH-1:0] tick_i = '0;
  logic [NUM_CH-1:0] pwm_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tcpwm_array #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_i(tick_i), .pwm_o(pwm_o)
  );

  function automatic logic [AW-1:0] ca(input int ch, input logic [1:0] sel);
    return {1'b0, 3'(ch), sel};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [15:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic ticks(input int ch, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_i = '0;
      tick_i[ch] = 1'b1;
    end
    @(negedge clk);
    tick_i = '0;
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 duty", ca(0, 2'd1), 16'hFFFF);
    rd_chk("R1 period", ca(7, 2'd2), 16'hFFFF);
    rd_chk("R1 count", ca(3, 2'd3), 16'h0000);
    rd_chk("R1 ctrl", ca(2, 2'd0), 16'h0000);
    rd_chk("R1 status", A_STS, 16'h0000);
    chk("R1 pwm", 16'(pwm_o), 16'h0000);

    // vector table on channel 0: R5 R6 R7 R11
    for (int v = 0; v < NV; v++) begin
      string tag;
      vec_t e = VECS[v];
      if (e.duty > e.period)      tag = "R7";
      else if (e.ticks > e.period) tag = "R5";
      else if (e.init_hi)          tag = "R11";
      else                         tag = "R6";
      wr(A_CLR, 16'h0001);
      wr(ca(0, 2'd3), 16'h0000);
      wr(ca(0, 2'd1), e.duty);
      wr(ca(0, 2'd2), e.period);
      wr(ca(0, 2'd0), {13'd0, 1'b1, e.init_hi, 1'b1});
      wr(A_SET, 16'h0001);
      ticks(0, int'(e.ticks));
      wr(A_CLR, 16'h0001);
      rd_chk({tag, " count"}, ca(0, 2'd3), e.exp_cnt);
      chk({tag, " pwm"}, 16'(pwm_o[0]), 16'(e.exp_pwm));
    end

    // R2 set mask, zero bits ignored
    wr(A_SET, 16'h000C);
    rd_chk("R2 set", A_STS, 16'h000C);
    wr(A_SET, 16'h0000);
    rd_chk("R2 zero set", A_STS, 16'h000C);
    wr(A_CLR, 16'h0000);
    rd_chk("R3 zero clr", A_STS, 16'h000C);

    // R3 clear
    wr(A_CLR, 16'h0008);
    rd_chk("R3 clr", A_STS, 16'h0004);

    // R4 ticks gate counting (channel 2 running)
    wr(ca(2, 2'd3), 16'h0000);
    repeat (5) @(negedge clk);
    rd_chk("R4 no tick", ca(2, 2'd3), 16'h0000);
    ticks(2, 3);
    rd_chk("R4 three ticks", ca(2, 2'd3), 16'h0003);
    wr(A_CLR, 16'h0004);
    ticks(2, 4);
    rd_chk("R3 stopped hold", ca(2, 2'd3), 16'h0003);
    rd_chk("R3 status", A_STS, 16'h0000);

    // R10 direct counter load and readback
    wr(ca(2, 2'd3), 16'h1234);
    rd_chk("R10 count", ca(2, 2'd3), 16'h1234);
    wr(ca(5, 2'd1), 16'h0ABC);
    rd_chk("R10 duty", ca(5, 2'd1), 16'h0ABC);

    // R8 abrupt shutdown on channel 1
    wr(ca(1, 2'd3), 16'h0000);
    wr(ca(1, 2'd1), 16'h0000);
    wr(ca(1, 2'd2), 16'd100);
    wr(ca(1, 2'd0), 16'h0005);
    wr(A_SET, 16'h0002);
    ticks(1, 1);
    chk("R8 on", 16'(pwm_o[1]), 16'h0001);
    wr(ca(1, 2'd0), 16'h0004);
    chk("R8 abrupt off", 16'(pwm_o[1]), 16'h0000);

    // R9 graceful shutdown
    wr(ca(1, 2'd0), 16'h0001);
    wr(ca(1, 2'd3), 16'h0000);
    wr(ca(1, 2'd2), 16'd3);
    ticks(1, 1);
    chk("R9 on", 16'(pwm_o[1]), 16'h0001);
    wr(ca(1, 2'd0), 16'h0000);
    chk("R9 drain", 16'(pwm_o[1]), 16'h0001);
    ticks(1, 2);
    rd_chk("R9 at period", ca(1, 2'd3), 16'd3);
    chk("R9 still live", 16'(pwm_o[1]), 16'h0001);
    ticks(1, 1);
    rd_chk("R5 wrap", ca(1, 2'd3), 16'd0);
    chk("R9 after wrap", 16'(pwm_o[1]), 16'h0000);

    finish_up();
  end
endmodule